// File: doc/BRIEF.md
# Serial Flash Command Decoder with Bank Register

This block sits behind the SPI slave pins of a serial NOR flash and decodes the incoming command bytes. It works in SPI mode 0 with one active-low select, most significant bit first. The SPI pins are oversampled by the system clock, so the serial clock must run several times slower than `clk`. The block holds a write-enable latch, a reset-arm latch and an 8-bit bank register.

The low two bits of the bank register extend a 24-bit command address to a 26-bit byte address. This reaches four 16 MiB banks without a 4-byte addressing mode. The bank register can be read and written by dedicated commands. Writes to it need the write-enable latch. A two-step soft reset clears it.

Erase commands that carry an address are turned into a one-cycle erase request. The request carries the widened address and a size flag. The array itself lies outside the block.

Top module: `spi_bank_cmd_decoder`

## Requirements
- R1: Opcode 0xC8 returns the bank register on `spi_miso` as one byte, MSB first, valid for sampling on the eight SCLK rising edges that follow the opcode.
- R2: Opcode 0xC5 with the write-enable latch set loads the next complete byte into the bank register, all 8 bits.
- R3: Opcode 0xC5 with the write-enable latch clear is ignored, and the bank register keeps its value.
- R4: Opcode 0x06 sets the write-enable latch and 0x04 clears it, each when select rises at the end of that frame.
- R5: The three address bytes arrive MSB first as bits [23:16], [15:8] and [7:0]. `erase_addr` is {bank[1:0], addr[23:0]}, and bank bits [7:2] have no effect.
- R6: Opcode 0x52 (32 KiB) and opcode 0xD8 (sector) give exactly one `erase_req` pulse, one cycle wide, after the third address byte. `erase_sector` is 0 for 0x52 and 1 for 0xD8.
- R7: A completed erase clears the write-enable latch, so a following 0xC5 is ignored.
- R8: Opcode 0x66 arms the soft reset. An armed 0x99 clears the bank register and the held `erase_addr` to 0. A 0x99 that is not armed has no effect.
- R9: Any opcode other than 0x99 that follows 0x66 disarms the reset, and a later 0x99 then has no effect.
- R10: Raising select before a command completes aborts it. There is no erase pulse, and a data byte with fewer than 8 bits leaves the bank register unchanged.
- R11: After reset, `erase_req` and `spi_miso` are 0 and the bank register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block, 0 when not selected |
| erase_req | output | 1 | One-cycle erase request |
| erase_addr | output | 26 | Widened erase byte address, held between requests |
| erase_sector | output | 1 | 1 for a sector erase, 0 for a 32 KiB erase |

## Verification
Two things change in the same clock edge when an erase completes: the request is issued with the address widened by the bank bits, and the write-enable latch drops. Erases are provoked at random bank values and addresses. Each one is judged by comparing the captured request with an address computed in the bench, and by a bank write sent right after it, which must be ignored. A second collision happens when a select rise that commits 0x06 is followed immediately by the next frame's 0xC5. The bench checks that the new latch value gates the write.

// File: rtl/spi_bank_pkg.sv
// Package: opcodes, controller states and deferred latch actions
// shared by the serial flash command decoder.
package spi_bank_pkg;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_ERS32K = 8'h52;
    localparam logic [7:0] OP_ERSSEC = 8'hD8;
    localparam logic [7:0] OP_BANKRD = 8'hC8;
    localparam logic [7:0] OP_BANKWR = 8'hC5;
    localparam logic [7:0] OP_RSTARM = 8'h66;
    localparam logic [7:0] OP_RSTGO  = 8'h99;

    typedef enum logic [1:0] {
        CS_IDLE,   // waiting for an opcode byte
        CS_ADDR,   // collecting erase address bytes
        CS_BANK,   // collecting the bank register byte
        CS_SKIP    // ignoring bytes until select rises
    } ctrl_state_t;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_SET,
        PEND_CLR
    } wel_pend_t;
endpackage

// File: rtl/spi_bank_rx.sv
// Module: spi_bank_rx
// Synchronises the SPI pins into clk, finds SCLK and select edges and
// assembles MSB-first bytes. Assumes SCLK is slower than clk/4.
// A partial byte is discarded whenever select is inactive.
module spi_bank_rx #(
    parameter int SYNC = 2,
    parameter int BW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_i,
    input  logic          cs_n_i,
    input  logic          mosi_i,
    output logic          sclk_fall,
    output logic          cs_rise,
    output logic          cs_act,
    output logic          byte_valid,
    output logic [BW-1:0] byte_data
);
    localparam int CW = $clog2(BW);

    logic [SYNC-1:0] sclk_q, cs_q, mosi_q;
    logic            sclk_d, cs_d;
    logic [BW-1:0]   sh;
    logic [CW-1:0]   cnt;
    logic            sclk_rise;

    // synchroniser chains and previous-value registers for edge finding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_q <= {sclk_q[SYNC-2:0], sclk_i};
            cs_q   <= {cs_q[SYNC-2:0], cs_n_i};
            mosi_q <= {mosi_q[SYNC-2:0], mosi_i};
            sclk_d <= sclk_q[SYNC-1];
            cs_d   <= cs_q[SYNC-1];
        end
    end

    // edge pulses from the synchronised pins
    always_comb begin
        sclk_rise = sclk_q[SYNC-1] & ~sclk_d;
        sclk_fall = ~sclk_q[SYNC-1] & sclk_d;
        cs_rise   = cs_q[SYNC-1] & ~cs_d;
        cs_act    = ~cs_q[SYNC-1];
    end

    // shift in one bit per rising SCLK edge and flag each full byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh         <= '0;
            cnt        <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (!cs_act) begin
                cnt <= '0;
            end else if (sclk_rise) begin
                sh  <= {sh[BW-2:0], mosi_q[SYNC-1]};
                cnt <= cnt + 1'b1;
                if (cnt == CW'(BW-1)) begin
                    byte_valid <= 1'b1;
                    byte_data  <= {sh[BW-2:0], mosi_q[SYNC-1]};
                end
            end
        end
    end

    AST_BYTE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R5
endmodule

// File: rtl/spi_bank_tx.sv
// Module: spi_bank_tx
// Drives MISO for the bank read. A load request arms the shifter. The next
// SCLK falling edge loads the value and later falling edges shift it.
// Assumes the request comes before the falling edge that ends the opcode.
module spi_bank_tx #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          sclk_fall,
    input  logic          load_req,
    input  logic [BW-1:0] load_val,
    output logic          miso
);
    logic [BW-1:0] sh;
    logic          pend;

    // arm, load and shift the outgoing byte within one select frame
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            sh   <= '0;
            pend <= 1'b0;
        end else begin
            if (load_req) pend <= 1'b1;
            if (sclk_fall) begin
                if (pend || load_req) begin
                    sh   <= load_val;
                    pend <= 1'b0;
                end else begin
                    sh <= {sh[BW-2:0], 1'b0};
                end
            end
        end
    end

    assign miso = sh[BW-1];

    AST_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso); // R11
endmodule

// File: rtl/spi_bank_ctrl.sv
// Module: spi_bank_ctrl
// Decodes opcode bytes, keeps the write-enable, reset-arm and bank
// registers, collects erase addresses and issues the erase request.
// Assumes bytes come from spi_bank_rx. A select rise always ends a command.
module spi_bank_ctrl
    import spi_bank_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int BANK_BITS  = 2,
    parameter int BW         = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cs_rise,
    input  logic                              byte_valid,
    input  logic [BW-1:0]                     byte_data,
    output logic [BW-1:0]                     bank,
    output logic                              rd_load,
    output logic                              erase_req,
    output logic [ADDR_BYTES*BW+BANK_BITS-1:0] cur_addr,
    output logic                              erase_sector
);
    localparam int ADDR_W = ADDR_BYTES * BW;
    localparam int EFF_W  = ADDR_W + BANK_BITS;
    localparam int BC_W   = $clog2(ADDR_BYTES + 1);

    ctrl_state_t       state;
    wel_pend_t         pend;
    logic              wel;
    logic              rst_arm;
    logic              sec_q;
    logic [ADDR_W-1:0] addr_sh;
    logic [BC_W-1:0]   bcnt;

    // command sequencing, latches, bank register and erase issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= CS_IDLE;
            pend         <= PEND_NONE;
            wel          <= 1'b0;
            rst_arm      <= 1'b0;
            sec_q        <= 1'b0;
            addr_sh      <= '0;
            bcnt         <= '0;
            bank         <= '0;
            rd_load      <= 1'b0;
            erase_req    <= 1'b0;
            cur_addr     <= '0;
            erase_sector <= 1'b0;
        end else begin
            erase_req <= 1'b0;
            rd_load   <= 1'b0;
            if (cs_rise) begin
                state <= CS_IDLE;
                bcnt  <= '0;
                pend  <= PEND_NONE;
                if (pend == PEND_SET) wel <= 1'b1;
                if (pend == PEND_CLR) wel <= 1'b0;
            end else if (byte_valid) begin
                unique case (state)
                    CS_IDLE: begin
                        rst_arm <= (byte_data == OP_RSTARM);
                        state   <= CS_SKIP;
                        case (byte_data)
                            OP_WREN: pend <= PEND_SET;
                            OP_WRDI: pend <= PEND_CLR;
                            OP_ERS32K, OP_ERSSEC: begin
                                state <= CS_ADDR;
                                sec_q <= (byte_data == OP_ERSSEC);
                                bcnt  <= '0;
                            end
                            OP_BANKRD: rd_load <= 1'b1;
                            OP_BANKWR: if (wel) state <= CS_BANK;
                            OP_RSTGO: begin
                                state <= CS_IDLE;
                                if (rst_arm) begin
                                    bank     <= '0;
                                    cur_addr <= '0;
                                end
                            end
                            default: ;
                        endcase
                    end
                    CS_ADDR: begin
                        addr_sh <= {addr_sh[ADDR_W-BW-1:0], byte_data};
                        bcnt    <= bcnt + 1'b1;
                        if (bcnt == BC_W'(ADDR_BYTES - 1)) begin
                            erase_req    <= 1'b1;
                            erase_sector <= sec_q;
                            cur_addr     <= {bank[BANK_BITS-1:0],
                                             addr_sh[ADDR_W-BW-1:0], byte_data};
                            wel          <= 1'b0;
                            state        <= CS_SKIP;
                        end
                    end
                    CS_BANK: begin
                        bank  <= byte_data;
                        state <= CS_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req); // R6
    AST_WEL_DROPS_ON_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !wel); // R7
    AST_BANK_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> cur_addr[EFF_W-1:ADDR_W] == bank[BANK_BITS-1:0]); // R5
    AST_BANK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !cs_rise && state == CS_IDLE && byte_data == OP_BANKWR && !wel)
        |=> $stable(bank)); // R3
    AST_NO_ERASE_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !erase_req); // R10
endmodule

// File: rtl/spi_bank_cmd_decoder.sv
// Module: spi_bank_cmd_decoder (top)
// Serial flash command front end: SPI receive, command control and
// bank read-back shifter. Assumes SCLK well below clk/4.
module spi_bank_cmd_decoder #(
    parameter int ADDR_BYTES = 3,
    parameter int BANK_BITS  = 2,
    parameter int SYNC       = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        erase_req,
    output logic [25:0] erase_addr,
    output logic        erase_sector
);
    localparam int BW    = 8;
    localparam int EFF_W = ADDR_BYTES * BW + BANK_BITS;

    logic          sclk_fall, cs_rise, cs_act, byte_valid, rd_load;
    logic [BW-1:0] byte_data, bank;
    logic [EFF_W-1:0] cur_addr;

    spi_bank_rx #(.SYNC(SYNC), .BW(BW)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n),
        .mosi_i(spi_mosi), .sclk_fall(sclk_fall), .cs_rise(cs_rise),
        .cs_act(cs_act), .byte_valid(byte_valid), .byte_data(byte_data)
    );

    spi_bank_ctrl #(.ADDR_BYTES(ADDR_BYTES), .BANK_BITS(BANK_BITS), .BW(BW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .byte_valid(byte_valid),
        .byte_data(byte_data), .bank(bank), .rd_load(rd_load),
        .erase_req(erase_req), .cur_addr(cur_addr), .erase_sector(erase_sector)
    );

    spi_bank_tx #(.BW(BW)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_fall(sclk_fall),
        .load_req(rd_load), .load_val(bank), .miso(spi_miso)
    );

    assign erase_addr = 26'(cur_addr);
endmodule

// File: tb/sim_spi_bank_cmd_decoder.sv
module sim_spi_bank_cmd_decoder;
    localparam int H = 8; // clk cycles per SCLK half period

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, erase_req, erase_sector;
    logic [25:0] erase_addr;

    int total = 0, bad = 0, pulses = 0;
    logic [25:0] cap_addr;
    logic        cap_sec;
    logic [7:0]  m_bank;
    logic        m_wel;

    always #4 clk = ~clk;

    spi_bank_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .erase_req(erase_req),
        .erase_addr(erase_addr), .erase_sector(erase_sector)
    );

    // capture erase pulses away from the active edge
    always @(negedge clk) if (rst_n && erase_req) begin
        pulses++;
        cap_addr = erase_addr;
        cap_sec  = erase_sector;
    end

    function automatic logic [25:0] exp_addr(input logic [7:0] b, input logic [23:0] a);
        return {b[1:0], a};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            wait_clk(H);
            rx[i] = miso;
            sclk = 1'b1;
            wait_clk(H);
            sclk = 1'b0;
        end
    endtask

    task automatic fstart();
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic fend();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(3 * H);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        fstart(); xfer(op, d); fend();
    endtask

    task automatic bank_rd(output logic [7:0] v);
        logic [7:0] d;
        fstart(); xfer(8'hC8, d); xfer(8'h00, v); fend();
    endtask

    task automatic bank_wr(input logic [7:0] v);
        logic [7:0] d;
        fstart(); xfer(8'hC5, d); xfer(v, d); fend();
    endtask

    task automatic erase(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] d;
        fstart(); xfer(op, d);
        xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
        fend();
    endtask

    task automatic check_bank(input string req, input logic [7:0] exp);
        logic [7:0] v;
        bank_rd(v);
        chk(v == exp, req, v, exp);
    endtask

    task automatic check_erase(input string req, input logic [7:0] op, input logic [23:0] a);
        int n0;
        n0 = pulses;
        erase(op, a);
        chk(pulses == n0 + 1, req, pulses - n0, 1);
        chk(cap_addr == exp_addr(m_bank, a), req, cap_addr, exp_addr(m_bank, a));
        chk(cap_sec == (op == 8'hD8), req, cap_sec, op == 8'hD8);
        m_wel = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n0;
        void'($urandom(32'd7));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);

        // R11: reset state
        chk(erase_req == 1'b0, "R11", erase_req, 0);
        chk(miso == 1'b0, "R11", miso, 0);
        check_bank("R11 R1", 8'h00);
        m_bank = 8'h00; m_wel = 1'b0;

        // R3: write without write enable is ignored
        bank_wr(8'hA5);
        check_bank("R3", 8'h00);

        // R4, R2: enable then write, select edge commits, next frame writes
        cmd1(8'h06);
        bank_wr(8'hA5);
        check_bank("R2 R4 R1", 8'hA5);
        m_bank = 8'hA5;

        // R4: disable blocks a write
        cmd1(8'h04);
        bank_wr(8'h3C);
        check_bank("R4", 8'hA5);

        // R5, R6: 32 KiB erase, bank bits 01
        check_erase("R5 R6", 8'h52, 24'h123456);
        // R7: erase dropped write enable
        bank_wr(8'h00);
        check_bank("R7", 8'hA5);

        // R5, R6: sector erase with bank 0xFE (upper bits set)
        cmd1(8'h06); bank_wr(8'hFE); m_bank = 8'hFE;
        check_erase("R5 R6", 8'hD8, 24'hABCDEF);

        // R10: aborted erase and partial bank byte
        cmd1(8'h06);
        n0 = pulses;
        fstart(); xfer(8'hD8, d); xfer(8'h11, d); xfer(8'h22, d); fend();
        chk(pulses == n0, "R10", pulses - n0, 0);
        fstart(); xfer(8'hC5, d);
        for (int i = 0; i < 4; i++) begin
            mosi = 1'b1; wait_clk(H); sclk = 1'b1; wait_clk(H); sclk = 1'b0;
        end
        fend();
        check_bank("R10", 8'hFE);

        // R8: unarmed reset does nothing
        cmd1(8'h99);
        check_bank("R8", 8'hFE);
        // R9: an opcode between arm and go disarms
        cmd1(8'h66); cmd1(8'h03); cmd1(8'h99);
        check_bank("R9", 8'hFE);
        // R8: armed reset clears bank and held address
        cmd1(8'h66); cmd1(8'h99);
        check_bank("R8", 8'h00);
        chk(erase_addr == 26'h0, "R8", erase_addr, 0);
        m_bank = 8'h00;
        cmd1(8'h04); m_wel = 1'b0;

        // random mix checked against the bench model
        for (int k = 0; k < 40; k++) begin
            int r;
            logic [7:0] v;
            r = $urandom % 5;
            case (r)
                0: begin cmd1(8'h06); m_wel = 1'b1; end
                1: begin cmd1(8'h04); m_wel = 1'b0; end
                2: begin
                    v = 8'($urandom);
                    bank_wr(v);
                    if (m_wel) m_bank = v;
                    check_bank(m_wel ? "R2" : "R3", m_bank);
                end
                3: check_erase("R5 R6 R7", ($urandom % 2) ? 8'hD8 : 8'h52, 24'($urandom));
                default: check_bank("R1", m_bank);
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule